// File: doc/BRIEF.md
# Sleep-Mode Power Request Sequencer

This block runs the handshake with an external power-management chip when the system goes into a low-power state and when it comes back out. Software picks one of three sleep depths through a two-bit mode input and then pulses a sleep request. The block raises the DRAM self-refresh request and the CPU rail-off request. After a programmed CPU-off delay it either settles into sleep or, in the deepest mode, also requests removal of the core rail, drops the system clock request and waits a programmed core-off delay.

A wake input starts the way back. In the deepest mode the block first asks for the system clock again and waits an oscillator-stable delay. It then releases the core rail-off request and waits a power-stable delay. In every mode it then releases the CPU rail-off request and waits a CPU power-good delay, which a synchronised power-good input from the power chip can cut short when that input is enabled. Finally it drops self-refresh and pulses `resume_done_o` for one cycle. All delays are given in microseconds and counted as ticks of a 32.768 kHz always-on timebase. Each microsecond value is converted to ticks by rounding up. The core request and system clock request have selectable polarity, and a combined option merges the CPU and core requests into one shared output.

Top module: `sleep_pwr_seq`

## Requirements
- R1: With mode 0 (deepest), a sleep request asserts self-refresh and the CPU-off request together. When the CPU-off wait ends, the core-off request asserts and the system clock request drops in the same cycle.
- R2: With mode 1, entry asserts self-refresh and the CPU-off request only. The core-off request and the system clock request keep their idle levels for the whole sequence.
- R3: With mode 2 (lightest), entry asserts only the CPU-off request. Self-refresh is never asserted.
- R4: Every wait lasts exactly ceil(us * 32768 / 1000000) pulses of `slow_tick_i`, counted from the cycle its starting output change appears. Wake is accepted only once the entry waits have finished.
- R5: In mode 0, wake first raises the system clock request, then waits the oscillator-stable time and releases the core-off request, then waits the power-stable time and releases the CPU-off request. After the CPU power-good time, self-refresh drops and `resume_done_o` is high for exactly one cycle.
- R6: In modes 1 and 2, wake releases the CPU-off request at once. After the CPU power-good time, self-refresh (if it was set) drops and `resume_done_o` pulses for one cycle.
- R7: `cpu_req_o` is active high (1 = remove CPU supply). `core_req_o` is 1 when a core-off request is active if `core_act_hi_i` is 1, and inverted otherwise. `sysclk_req_o` is 1 when the clock is needed if `sysclk_act_hi_i` is 1, and inverted otherwise.
- R8: With `combined_req_i` = 1, `cpu_req_o` stays 0 and the shared request on `core_req_o` is active whenever either the CPU-off or the core-off request is active.
- R9: With `cpu_pg_en_i` = 1, a high `cpu_pg_i` ends the CPU power-good wait within SYNC_STAGES + 2 cycles. With `cpu_pg_en_i` = 0, `cpu_pg_i` has no effect and the full wait runs.
- R10: A sleep request arriving while a sequence runs is ignored and not queued. A request with mode 3 is ignored.
- R11: After reset, all off-requests and self-refresh are inactive, the system clock request is active and `resume_done_o` is 0.
- R12: The mode is captured at entry. Changes on `mode_i` during a sequence do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | One-cycle pulse per 32.768 kHz timebase period |
| mode_i | input | 2 | Sleep depth: 0 deep, 1 mid, 2 light, 3 reserved |
| sleep_req_i | input | 1 | Start entry (sampled when idle) |
| wake_i | input | 1 | Wake event, level |
| cpu_off_us_i | input | US_W | CPU power-off delay, microseconds |
| core_off_us_i | input | US_W | Core power-off delay, microseconds |
| osc_stable_us_i | input | US_W | Oscillator-stable delay, microseconds |
| pwr_stable_us_i | input | US_W | Core power-stable delay, microseconds |
| cpu_good_us_i | input | US_W | CPU power-good delay, microseconds |
| core_act_hi_i | input | 1 | Core request polarity: 1 active high |
| sysclk_act_hi_i | input | 1 | System clock request polarity: 1 active high |
| combined_req_i | input | 1 | Merge CPU and core requests onto core_req_o |
| cpu_pg_en_i | input | 1 | Honour the CPU power-good input |
| cpu_pg_i | input | 1 | CPU power-good from the power chip, asynchronous |
| cpu_req_o | output | 1 | CPU supply-off request |
| core_req_o | output | 1 | Core (or shared) supply-off request |
| sysclk_req_o | output | 1 | System clock request |
| dram_sr_req_o | output | 1 | DRAM self-refresh request |
| resume_done_o | output | 1 | One-cycle pulse when resume completes |

## Verification
The hardest case to reach is the deepest-mode exit with combined requests. There, releasing the core-off request is invisible at the pins because the shared request stays held by the CPU side. The bench handles this by counting timebase pulses between visible output changes and expecting the oscillator-stable and power-stable counts to add up in that case. Wake is held high from the start of each sequence, so the measured span of the last entry wait also shows that wake is not taken early. The sweep covers every mode against every polarity and combine setting, with delay values chosen so that the rounding up to ticks matters.

// File: rtl/sleep_pwr_seq_pkg.sv
package sleep_pwr_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ENTER_CPU,
      ST_ENTER_CORE,
      ST_ASLEEP,
      ST_OSC_WAIT,
      ST_PWR_WAIT,
      ST_CPU_GOOD
   } seq_state_e;

   typedef enum logic [1:0] {
      MODE_DEEP  = 2'd0,
      MODE_MID   = 2'd1,
      MODE_LIGHT = 2'd2,
      MODE_RSVD  = 2'd3
   } sleep_mode_e;

   localparam int NUM_IV      = 5;
   localparam int IV_CPU_OFF  = 0;
   localparam int IV_CORE_OFF = 1;
   localparam int IV_OSC      = 2;
   localparam int IV_PWR      = 3;
   localparam int IV_CPU_GOOD = 4;

endpackage

// File: rtl/sleep_pwr_seq_us2tick.sv
module sleep_pwr_seq_us2tick #(
   parameter int US_W    = 16,
   parameter int TICK_W  = 16,
   parameter int SLOW_HZ = 32768
) (
   input  logic [US_W-1:0]   us_i,
   output logic [TICK_W-1:0] ticks_o
);
   localparam int PW = US_W + $clog2(SLOW_HZ + 1) + 21;
   localparam logic [PW-1:0] HZ_K   = PW'(SLOW_HZ);
   localparam logic [PW-1:0] MEGA_K = PW'(1000000);
   localparam logic [PW-1:0] RUP_K  = PW'(999999);

   generate
      if (SLOW_HZ < 1 || SLOW_HZ > 1000000) begin : g_bad_hz
         $error("SLOW_HZ must lie between 1 and 1000000");
      end
      if (TICK_W < US_W) begin : g_bad_tw
         $error("TICK_W must be at least US_W");
      end
   endgenerate

   logic [PW-1:0] prod;
   assign prod    = PW'(us_i) * HZ_K;
   assign ticks_o = TICK_W'((prod + RUP_K) / MEGA_K);

endmodule

// File: rtl/sleep_pwr_seq_timer.sv
module sleep_pwr_seq_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         tick_i,
   output logic         expire_o
);
   generate
      if (W < 2) begin : g_bad_w
         $error("timer width must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (tick_i && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire_o = (cnt_q == '0) || (tick_i && cnt_q == W'(1));

   // R4
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

   // R4
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/sleep_pwr_seq_sync.sv
module sleep_pwr_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES:0] chain;
   assign chain[0] = d_i;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s+1] <= 1'b0;
            else        chain[s+1] <= chain[s];
         end
      end
   endgenerate

   assign q_o = chain[STAGES];

endmodule

// File: rtl/sleep_pwr_seq.sv
module sleep_pwr_seq
   import sleep_pwr_seq_pkg::*;
#(
   parameter int US_W        = 16,
   parameter int SLOW_HZ     = 32768,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slow_tick_i,
   input  logic [1:0]      mode_i,
   input  logic            sleep_req_i,
   input  logic            wake_i,
   input  logic [US_W-1:0] cpu_off_us_i,
   input  logic [US_W-1:0] core_off_us_i,
   input  logic [US_W-1:0] osc_stable_us_i,
   input  logic [US_W-1:0] pwr_stable_us_i,
   input  logic [US_W-1:0] cpu_good_us_i,
   input  logic            core_act_hi_i,
   input  logic            sysclk_act_hi_i,
   input  logic            combined_req_i,
   input  logic            cpu_pg_en_i,
   input  logic            cpu_pg_i,
   output logic            cpu_req_o,
   output logic            core_req_o,
   output logic            sysclk_req_o,
   output logic            dram_sr_req_o,
   output logic            resume_done_o
);
   localparam int TICK_W = US_W;

   generate
      if (US_W < 4) begin : g_bad_usw
         $error("US_W must be at least 4");
      end
   endgenerate

   // interval conversion, one converter per programmed delay
   logic [US_W-1:0]   iv_us [NUM_IV];
   logic [TICK_W-1:0] iv_tk [NUM_IV];

   assign iv_us[IV_CPU_OFF]  = cpu_off_us_i;
   assign iv_us[IV_CORE_OFF] = core_off_us_i;
   assign iv_us[IV_OSC]      = osc_stable_us_i;
   assign iv_us[IV_PWR]      = pwr_stable_us_i;
   assign iv_us[IV_CPU_GOOD] = cpu_good_us_i;

   generate
      for (genvar g = 0; g < NUM_IV; g++) begin : g_cvt
         sleep_pwr_seq_us2tick #(
            .US_W    (US_W),
            .TICK_W  (TICK_W),
            .SLOW_HZ (SLOW_HZ)
         ) i_cvt (
            .us_i    (iv_us[g]),
            .ticks_o (iv_tk[g])
         );
      end
   endgenerate

   // power-good synchroniser
   logic pg_sync;
   sleep_pwr_seq_sync #(.STAGES(SYNC_STAGES)) i_pg_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cpu_pg_i),
      .q_o   (pg_sync)
   );

   // sequencer state
   seq_state_e  state_q, state_d;
   sleep_mode_e mode_q, mode_d;
   logic cpu_off_q, cpu_off_d;
   logic core_off_q, core_off_d;
   logic clk_need_q, clk_need_d;
   logic sr_q, sr_d;
   logic done_q, done_d;

   logic              tmr_load;
   logic [TICK_W-1:0] tmr_val;
   logic              tmr_expire;
   logic              pg_early;

   assign pg_early = cpu_pg_en_i && pg_sync;

   sleep_pwr_seq_timer #(.W(TICK_W)) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .tick_i     (slow_tick_i),
      .expire_o   (tmr_expire)
   );

   always_comb begin
      state_d    = state_q;
      mode_d     = mode_q;
      cpu_off_d  = cpu_off_q;
      core_off_d = core_off_q;
      clk_need_d = clk_need_q;
      sr_d       = sr_q;
      done_d     = 1'b0;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (sleep_req_i && mode_i != MODE_RSVD) begin
               mode_d    = sleep_mode_e'(mode_i);
               sr_d      = (mode_i != MODE_LIGHT);
               cpu_off_d = 1'b1;
               tmr_load  = 1'b1;
               tmr_val   = iv_tk[IV_CPU_OFF];
               state_d   = ST_ENTER_CPU;
            end
         end
         ST_ENTER_CPU: begin
            if (tmr_expire) begin
               if (mode_q == MODE_DEEP) begin
                  core_off_d = 1'b1;
                  clk_need_d = 1'b0;
                  tmr_load   = 1'b1;
                  tmr_val    = iv_tk[IV_CORE_OFF];
                  state_d    = ST_ENTER_CORE;
               end else begin
                  state_d = ST_ASLEEP;
               end
            end
         end
         ST_ENTER_CORE: begin
            if (tmr_expire) state_d = ST_ASLEEP;
         end
         ST_ASLEEP: begin
            if (wake_i) begin
               tmr_load = 1'b1;
               if (mode_q == MODE_DEEP) begin
                  clk_need_d = 1'b1;
                  tmr_val    = iv_tk[IV_OSC];
                  state_d    = ST_OSC_WAIT;
               end else begin
                  cpu_off_d = 1'b0;
                  tmr_val   = iv_tk[IV_CPU_GOOD];
                  state_d   = ST_CPU_GOOD;
               end
            end
         end
         ST_OSC_WAIT: begin
            if (tmr_expire) begin
               core_off_d = 1'b0;
               tmr_load   = 1'b1;
               tmr_val    = iv_tk[IV_PWR];
               state_d    = ST_PWR_WAIT;
            end
         end
         ST_PWR_WAIT: begin
            if (tmr_expire) begin
               cpu_off_d = 1'b0;
               tmr_load  = 1'b1;
               tmr_val   = iv_tk[IV_CPU_GOOD];
               state_d   = ST_CPU_GOOD;
            end
         end
         ST_CPU_GOOD: begin
            if (tmr_expire || pg_early) begin
               sr_d    = 1'b0;
               done_d  = 1'b1;
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         mode_q     <= MODE_DEEP;
         cpu_off_q  <= 1'b0;
         core_off_q <= 1'b0;
         clk_need_q <= 1'b1;
         sr_q       <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         state_q    <= state_d;
         mode_q     <= mode_d;
         cpu_off_q  <= cpu_off_d;
         core_off_q <= core_off_d;
         clk_need_q <= clk_need_d;
         sr_q       <= sr_d;
         done_q     <= done_d;
      end
   end

   // output polarity and request merging
   logic core_level;
   assign core_level    = combined_req_i ? (cpu_off_q | core_off_q) : core_off_q;
   assign cpu_req_o     = combined_req_i ? 1'b0 : cpu_off_q;
   assign core_req_o    = core_act_hi_i ? core_level : ~core_level;
   assign sysclk_req_o  = sysclk_act_hi_i ? clk_need_q : ~clk_need_q;
   assign dram_sr_req_o = sr_q;
   assign resume_done_o = done_q;

   // R3
   light_no_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && mode_q == MODE_LIGHT) |-> !sr_q);

   // R1
   core_deep_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_off_q |-> (mode_q == MODE_DEEP && cpu_off_q));

   // R5
   clk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_need_q |-> core_off_q);

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R12
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(mode_q));

   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ENTER_CPU && sleep_req_i) |=> $stable(mode_q));

endmodule

// File: tb/test_sleep_pwr_seq.sv
module test_sleep_pwr_seq;
   localparam int US_W = 16;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n;
   logic [1:0] tdiv;
   logic slow_tick;
   logic [1:0] mode;
   logic sleep_req, wake;
   logic [US_W-1:0] off_us, core_us, osc_us, pwr_us, good_us;
   logic core_hi, sys_hi, comb, pg_en, pg;
   logic cpu_req, core_req, sysclk_req, sr_req, done;

   int n_chk = 0;
   int n_fail = 0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tdiv <= '0;
      else        tdiv <= tdiv + 2'd1;
   end
   assign slow_tick = (tdiv == 2'd3);

   sleep_pwr_seq #(.US_W(US_W), .SLOW_HZ(32768), .SYNC_STAGES(SYNC)) i_sleep_pwr_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .slow_tick_i     (slow_tick),
      .mode_i          (mode),
      .sleep_req_i     (sleep_req),
      .wake_i          (wake),
      .cpu_off_us_i    (off_us),
      .core_off_us_i   (core_us),
      .osc_stable_us_i (osc_us),
      .pwr_stable_us_i (pwr_us),
      .cpu_good_us_i   (good_us),
      .core_act_hi_i   (core_hi),
      .sysclk_act_hi_i (sys_hi),
      .combined_req_i  (comb),
      .cpu_pg_en_i     (pg_en),
      .cpu_pg_i        (pg),
      .cpu_req_o       (cpu_req),
      .core_req_o      (core_req),
      .sysclk_req_o    (sysclk_req),
      .dram_sr_req_o   (sr_req),
      .resume_done_o   (done)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_tk(input int us);
      longint p;
      p = longint'(us) * 32768;
      return int'((p + 999999) / 1000000);
   endfunction

   function automatic logic [4:0] obs();
      return {cpu_req, core_req, sysclk_req, sr_req, done};
   endfunction

   function automatic logic [4:0] ev(input logic cpu_off, input logic core_off,
                                     input logic clk_need, input logic sr, input logic dn);
      logic c_o, lvl, k_o, s_o;
      c_o = comb ? 1'b0 : cpu_off;
      lvl = comb ? (cpu_off | core_off) : core_off;
      k_o = core_hi ? lvl : ~lvl;
      s_o = sys_hi ? clk_need : ~clk_need;
      return {c_o, k_o, s_o, sr, dn};
   endfunction

   task automatic wait_change(output int tk, output int cyc);
      logic [4:0] prev;
      prev = obs();
      tk = 0;
      cyc = 0;
      while (cyc < 5000) begin
         if (slow_tick) tk++;
         @(negedge clk);
         cyc++;
         if (obs() != prev) break;
      end
   endtask

   task automatic check_vec(input string tag, input logic [4:0] e);
      check(obs() == e, tag, longint'(obs()), longint'(e));
   endtask

   task automatic run_seq(input int m, input bit cb, input bit ch, input bit sh,
                          input bit pen, input bit pgv, input bit hold, input int salt);
      int tk, cyc;
      bit stayed;
      logic sr_exp;
      comb    = cb;
      core_hi = ch;
      sys_hi  = sh;
      pg_en   = pen;
      off_us  = US_W'(40 + salt * 13);
      core_us = US_W'(100 + salt * 29);
      osc_us  = US_W'(30 + salt * 7);
      pwr_us  = US_W'(60 + salt * 11);
      good_us = US_W'(90 + salt * 17);
      sr_exp  = (m != 2);
      repeat (3) @(negedge clk);
      check_vec("R7 idle polarity", ev(0, 0, 1, 0, 0));
      pg        = pgv;
      wake      = 1'b1;
      mode      = 2'(m);
      sleep_req = 1'b1;
      @(negedge clk);
      if (hold) mode = 2'((m + 1) % 3);
      else      sleep_req = 1'b0;
      if (m == 0)      check_vec("R1 deep entry", ev(1, 0, 1, 1, 0));
      else if (m == 1) check_vec("R2 mid entry", ev(1, 0, 1, 1, 0));
      else             check_vec("R3 light entry", ev(1, 0, 1, 0, 0));
      wait_change(tk, cyc);
      check(tk == exp_tk(int'(off_us)), "R4 cpu-off ticks", tk, exp_tk(int'(off_us)));
      if (m == 0) begin
         check_vec("R1 core off and clock drop", ev(1, 1, 0, 1, 0));
         wait_change(tk, cyc);
         check(tk == exp_tk(int'(core_us)), "R4 core-off ticks", tk, exp_tk(int'(core_us)));
         check_vec("R5 clock request first", ev(1, 1, 1, 1, 0));
         if (cb) begin
            wait_change(tk, cyc);
            check(tk == exp_tk(int'(osc_us)) + exp_tk(int'(pwr_us)), "R8 merged osc+pwr ticks",
                  tk, exp_tk(int'(osc_us)) + exp_tk(int'(pwr_us)));
         end else begin
            wait_change(tk, cyc);
            check(tk == exp_tk(int'(osc_us)), "R5 osc ticks", tk, exp_tk(int'(osc_us)));
            check_vec("R5 core release", ev(1, 0, 1, 1, 0));
            wait_change(tk, cyc);
            check(tk == exp_tk(int'(pwr_us)), "R5 pwr ticks", tk, exp_tk(int'(pwr_us)));
         end
         check_vec("R5 cpu release", ev(0, 0, 1, 1, 0));
      end else begin
         check_vec(m == 1 ? "R2 R6 cpu release" : "R3 R6 cpu release", ev(0, 0, 1, sr_exp, 0));
      end
      wait_change(tk, cyc);
      if (pen && pgv)
         check(cyc <= SYNC + 2, "R9 early power-good", cyc, SYNC + 2);
      else
         check(tk == exp_tk(int'(good_us)), "R9 R6 cpu-good ticks", tk, exp_tk(int'(good_us)));
      check_vec(hold ? "R12 mode captured, done" : "R5 R6 done", ev(0, 0, 1, 0, 1));
      if (hold) sleep_req = 1'b0;
      @(negedge clk);
      check_vec("R5 done one cycle", ev(0, 0, 1, 0, 0));
      if (hold) begin
         stayed = 1'b1;
         repeat (30) begin
            @(negedge clk);
            if (obs() != ev(0, 0, 1, 0, 0)) stayed = 1'b0;
         end
         check(stayed, "R10 busy request not queued", stayed, 1);
      end
      wake = 1'b0;
      pg   = 1'b0;
   endtask

   task automatic main_body();
      int salt;
      bit stayed;
      salt = 0;
      rst_n = 1'b0; mode = '0; sleep_req = 1'b0; wake = 1'b0;
      off_us = '0; core_us = '0; osc_us = '0; pwr_us = '0; good_us = '0;
      core_hi = 1'b1; sys_hi = 1'b1; comb = 1'b0; pg_en = 1'b0; pg = 1'b0;
      repeat (3) @(negedge clk);
      check(obs() == 5'b00100, "R11 reset state", longint'(obs()), 4);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(obs() == 5'b00100, "R11 after reset", longint'(obs()), 4);

      for (int m = 0; m < 3; m++)
         for (int cb = 0; cb < 2; cb++)
            for (int ch = 0; ch < 2; ch++)
               for (int sh = 0; sh < 2; sh++) begin
                  run_seq(m, cb[0], ch[0], sh[0], 1'b0, 1'b0, 1'b0, salt);
                  salt++;
               end
      for (int m = 0; m < 3; m++) begin
         run_seq(m, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, salt); salt++;
         run_seq(m, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, salt); salt++;
         run_seq(m, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, salt); salt++;
      end

      // reserved mode request must be ignored
      core_hi = 1'b1; sys_hi = 1'b1; comb = 1'b0;
      @(negedge clk);
      mode = 2'd3; sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      stayed = 1'b1;
      repeat (40) begin
         if (obs() != 5'b00100) stayed = 1'b0;
         @(negedge clk);
      end
      check(stayed, "R10 reserved mode ignored", stayed, 1);
   endtask

   initial begin
      fork
         main_body();
         begin
            repeat (150000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule